// File: doc/BRIEF.md
# Swept-Delay Jitter Histogram Accumulator

This block is the digital back end of an on-chip jitter and skew measurement. A sense flip-flop compares a delayed copy of a data edge against a clock and reports, once per cycle, whether the data edge came first (an "early" hit). The block steps a delay code through every setting of a delay line. At each setting it counts the early hits over a fixed number of samples. The counts, taken in code order, form a cumulative distribution of edge arrival time.

Each measurement runs two full sweeps back to back against one fixed reference clock. The block then differences adjacent counts to form one histogram per sweep, finds the centroid of each histogram, and reports the signed distance between the two centroids as a skew estimate in delay-code units, with fractional bits. Period jitter is measured by feeding the sense flip-flop from two paths whose delays differ by one clock period, so the histogram width is the period spread. The histogram bins stay readable through a combinational port until the next start.

Top module: `jitter_hist_acc`

## Requirements
- R1: After reset, busy_o, done_o, delay_code_o, sweep_o and skew_o are all zero. Whenever busy_o is low, delay_code_o and sweep_o are zero.
- R2: A start_i pulse while idle begins sweep 0 at code 0. Each code is held for NSAMP cycles in ascending order from 0 to NCODES-1, and then sweep 1 (sweep_o=1) repeats the same order. sample_i is taken at the rising edge that follows each cycle in which delay_code_o shows the code it belongs to.
- R3: The count stored for a (sweep, code) pair is the number of cycles with sample_i=1 among its NSAMP samples, saturating at 2^CNT_W-1.
- R4: rd_bin_o shows the histogram bin rd_idx_i of sweep rd_sweep_i, combinationally. Bin k equals count[k+1] minus count[k] when that difference is positive, and 0 otherwise. Indices NCODES-1 and above read 0. The bins hold their values until the next start.
- R5: skew_o is a two's complement value with FRAC_W fractional bits equal to (C1 - C0)·2^FRAC_W, truncated toward zero. Here Cs = Σ k·bin_s[k] / Σ bin_s[k], taken over k = 0..NCODES-2.
- R6: If either sweep's histogram sums to zero, skew_o becomes 0.
- R7: done_o is a one-cycle pulse in the cycle that skew_o takes its new value, and busy_o is already low in that cycle. skew_o does not change in any other cycle.
- R8: start_i is ignored while busy_o is high. The run in progress completes with unchanged results and a single done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a two-sweep measurement when idle |
| sample_i | input | 1 | Early-hit decision from the sense flip-flop |
| delay_code_o | output | CODE_W | Delay setting under test |
| sweep_o | output | 1 | Sweep under test (0 or 1) |
| rd_sweep_i | input | 1 | Sweep selected for bin read-out |
| rd_idx_i | input | CODE_W | Bin index for read-out |
| rd_bin_o | output | CNT_W | Histogram bin value |
| skew_o | output | SKEW_W | Signed centroid difference, FRAC_W fractional bits |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with NCODES=8, NSAMP=40, CNT_W=5 and FRAC_W=4. With these values one measurement takes about 700 cycles, so dozens of threshold patterns fit in a run: step edges in both directions, ramps, non-monotone count sequences, empty histograms and random thresholds. Because 40 samples per code exceed the 31 that a 5-bit count holds, saturation is reached on every pattern that asks for it. The bench computes every bin and every skew value arithmetically and compares them against the outputs.

// File: rtl/jh_pkg.sv
package jh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_ACCUM,
    ST_MULT,
    ST_DIVIDE
  } jh_state_e;
endpackage

// File: rtl/jh_hit_counter.sv
module jh_hit_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    nxt_o = cnt_q;
    if (en_i && hit_i && (cnt_q != CNT_MAX)) nxt_o = cnt_q + 1'b1;
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/jh_centroid_acc.sv
module jh_centroid_acc #(
  parameter int CNT_W  = 11,
  parameter int CODE_W = 5,
  parameter int TOT_W  = 16,
  parameter int WS_W   = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] idx_i,
  input  logic [CNT_W-1:0]  bin_i,
  output logic [WS_W-1:0]   wsum_o,
  output logic [TOT_W-1:0]  tot_o
);
  logic [WS_W-1:0]  wsum_q, wsum_d;
  logic [TOT_W-1:0] tot_q, tot_d;

  always_comb begin
    wsum_d = wsum_q;
    tot_d  = tot_q;
    if (clr_i) begin
      wsum_d = '0;
      tot_d  = '0;
    end else if (en_i) begin
      wsum_d = wsum_q + WS_W'(idx_i) * WS_W'(bin_i);
      tot_d  = tot_q + TOT_W'(bin_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsum_q <= '0;
      tot_q  <= '0;
    end else begin
      wsum_q <= wsum_d;
      tot_q  <= tot_d;
    end
  end

  assign wsum_o = wsum_q;
  assign tot_o  = tot_q;
endmodule

// File: rtl/jh_seq_div.sv
module jh_seq_div #(
  parameter int NUM_W = 41,
  parameter int DEN_W = 32,
  parameter int Q_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NUM_W-1:0]      num_i,
  input  logic [DEN_W-1:0]      den_i,
  input  logic                  neg_i,
  output logic                  done_o,
  output logic signed [Q_W-1:0] quo_o
);
  localparam int IT_W = $clog2(NUM_W + 1);
  localparam logic [IT_W-1:0] IT_LAST = IT_W'(NUM_W - 1);

  logic [DEN_W-1:0] rem_q, rem_d, den_q;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [IT_W-1:0]  it_q, it_d;
  logic             run_q, run_d, done_q, done_d, neg_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;
  logic signed [Q_W-1:0] qmag;

  always_comb begin
    trial  = {rem_q, quo_q[NUM_W-1]};
    diff   = trial - {1'b0, den_q};
    ge     = (trial >= {1'b0, den_q});
    rem_d  = rem_q;
    quo_d  = quo_q;
    it_d   = it_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start_i) begin
      rem_d = '0;
      quo_d = num_i;
      it_d  = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_d = {quo_q[NUM_W-2:0], ge};
      it_d  = it_q + 1'b1;
      if (it_q == IT_LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      it_q   <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      den_q  <= '0;
      neg_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      it_q   <= it_d;
      run_q  <= run_d;
      done_q <= done_d;
      if (start_i) begin
        den_q <= den_i;
        neg_q <= neg_i;
      end
    end
  end

  assign qmag   = {1'b0, quo_q[Q_W-2:0]};
  assign quo_o  = neg_q ? -qmag : qmag;
  assign done_o = done_q;
endmodule

// File: rtl/jitter_hist_acc.sv
module jitter_hist_acc #(
  parameter int NCODES = 32,
  parameter int NSAMP  = 1024,
  parameter int CNT_W  = 11,
  parameter int FRAC_W = 4,
  localparam int CODE_W = $clog2(NCODES),
  localparam int SKEW_W = CODE_W + FRAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     sample_i,
  output logic [CODE_W-1:0]        delay_code_o,
  output logic                     sweep_o,
  input  logic                     rd_sweep_i,
  input  logic [CODE_W-1:0]        rd_idx_i,
  output logic [CNT_W-1:0]         rd_bin_o,
  output logic signed [SKEW_W-1:0] skew_o,
  output logic                     busy_o,
  output logic                     done_o
);
  import jh_pkg::*;

  localparam int SAMP_W = $clog2(NSAMP);
  localparam int NBINS  = NCODES - 1;
  localparam int TOT_W  = CNT_W + CODE_W;
  localparam int WS_W   = TOT_W + CODE_W;
  localparam int WT_W   = WS_W + TOT_W;
  localparam int NUM_W  = WT_W + FRAC_W;
  localparam int DEN_W  = 2 * TOT_W;
  localparam logic [SAMP_W-1:0] SAMP_LAST = SAMP_W'(NSAMP - 1);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(NCODES - 1);
  localparam logic [CODE_W-1:0] BIN_LAST  = CODE_W'(NBINS - 1);

  jh_state_e state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d, acc_q, acc_d;
  logic [SAMP_W-1:0] samp_q, samp_d;
  logic              sweep_q, sweep_d, done_q, done_d;
  logic signed [SKEW_W-1:0] skew_q, skew_d;

  logic cnt_clr, cnt_en, cdf_we, acc_clr, acc_en, div_start, div_done;
  logic [CNT_W-1:0] cnt_cur, cnt_nxt;
  logic [CNT_W-1:0] cdf_q [2][NCODES];
  logic [CNT_W-1:0] acc_bin [2];
  logic [WS_W-1:0]  wsum_w [2];
  logic [TOT_W-1:0] tot_w [2];
  logic [WT_W-1:0]  prod_hi, prod_lo, prod_mag;
  logic [NUM_W-1:0] div_num;
  logic [DEN_W-1:0] div_den;
  logic             div_neg, tot_zero;
  logic signed [SKEW_W-1:0] div_q;

  function automatic logic [CNT_W-1:0] bin_of(input logic s, input logic [CODE_W-1:0] k);
    logic [CODE_W-1:0] kn;
    bin_of = '0;
    kn = k + 1'b1;
    if (int'(k) < NBINS) begin
      if (cdf_q[s][kn] > cdf_q[s][k]) bin_of = cdf_q[s][kn] - cdf_q[s][k];
    end
  endfunction

  jh_hit_counter #(.CNT_W(CNT_W)) u_hits (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en),
    .hit_i(sample_i), .cnt_o(cnt_cur), .nxt_o(cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (cdf_we) cdf_q[sweep_q][code_q] <= cnt_nxt;
  end

  for (genvar s = 0; s < 2; s++) begin : g_acc
    always_comb acc_bin[s] = bin_of(s[0], acc_q);
    jh_centroid_acc #(.CNT_W(CNT_W), .CODE_W(CODE_W), .TOT_W(TOT_W), .WS_W(WS_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .en_i(acc_en),
      .idx_i(acc_q), .bin_i(acc_bin[s]), .wsum_o(wsum_w[s]), .tot_o(tot_w[s])
    );
  end

  always_comb begin
    prod_hi  = WT_W'(wsum_w[1]) * WT_W'(tot_w[0]);
    prod_lo  = WT_W'(wsum_w[0]) * WT_W'(tot_w[1]);
    div_neg  = prod_lo > prod_hi;
    prod_mag = div_neg ? (prod_lo - prod_hi) : (prod_hi - prod_lo);
    div_num  = {prod_mag, {FRAC_W{1'b0}}};
    div_den  = DEN_W'(tot_w[0]) * DEN_W'(tot_w[1]);
    tot_zero = (tot_w[0] == '0) || (tot_w[1] == '0);
  end

  jh_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(SKEW_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start), .num_i(div_num),
    .den_i(div_den), .neg_i(div_neg), .done_o(div_done), .quo_o(div_q)
  );

  always_comb begin
    state_d = state_q;  code_d = code_q;  sweep_d = sweep_q;
    samp_d  = samp_q;   acc_d  = acc_q;   skew_d  = skew_q;
    done_d  = 1'b0;     cnt_clr = 1'b0;   cnt_en  = 1'b0;
    cdf_we  = 1'b0;     acc_clr = 1'b0;   acc_en  = 1'b0;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SAMPLE;
        code_d  = '0;
        sweep_d = 1'b0;
        samp_d  = '0;
        cnt_clr = 1'b1;
        acc_clr = 1'b1;
      end
      ST_SAMPLE: begin
        cnt_en = 1'b1;
        if (samp_q == SAMP_LAST) begin
          cdf_we  = 1'b1;
          cnt_clr = 1'b1;
          samp_d  = '0;
          if (code_q == CODE_LAST) begin
            code_d = '0;
            if (sweep_q) begin
              sweep_d = 1'b0;
              acc_d   = '0;
              state_d = ST_ACCUM;
            end else begin
              sweep_d = 1'b1;
            end
          end else begin
            code_d = code_q + 1'b1;
          end
        end else begin
          samp_d = samp_q + 1'b1;
        end
      end
      ST_ACCUM: begin
        acc_en = 1'b1;
        if (acc_q == BIN_LAST) state_d = ST_MULT;
        else                   acc_d   = acc_q + 1'b1;
      end
      ST_MULT: begin
        if (tot_zero) begin
          skew_d  = '0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          div_start = 1'b1;
          state_d   = ST_DIVIDE;
        end
      end
      ST_DIVIDE: if (div_done) begin
        skew_d  = div_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      sweep_q <= 1'b0;
      samp_q  <= '0;
      acc_q   <= '0;
      skew_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      sweep_q <= sweep_d;
      samp_q  <= samp_d;
      acc_q   <= acc_d;
      skew_q  <= skew_d;
      done_q  <= done_d;
    end
  end

  always_comb rd_bin_o = bin_of(rd_sweep_i, rd_idx_i);

  assign delay_code_o = code_q;
  assign sweep_o      = sweep_q;
  assign skew_o       = skew_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
endmodule

// File: rtl/jitter_hist_acc_chk.sv
module jitter_hist_acc_chk #(
  parameter int NCODES = 32,
  parameter int CNT_W  = 11,
  parameter int CODE_W = 5,
  parameter int SKEW_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CODE_W-1:0]        delay_code_o,
  input logic                     sweep_o,
  input logic [CODE_W-1:0]        rd_idx_i,
  input logic [CNT_W-1:0]         rd_bin_o,
  input logic signed [SKEW_W-1:0] skew_o,
  input logic                     busy_o,
  input logic                     done_o
);
  a_r1_idle_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (delay_code_o == '0) && !sweep_o);

  a_r2_code_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      (delay_code_o == $past(delay_code_o)) ||
      (delay_code_o == CODE_W'($past(delay_code_o) + 1'b1)) ||
      (delay_code_o == '0));

  a_r2_sweep_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_o) |-> (delay_code_o == '0));

  a_r4_no_bin_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx_i) >= NCODES - 1) |-> (rd_bin_o == '0));

  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r7_skew_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(skew_o));
endmodule

bind jitter_hist_acc jitter_hist_acc_chk #(
  .NCODES(NCODES), .CNT_W(CNT_W), .CODE_W(CODE_W), .SKEW_W(SKEW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .delay_code_o(delay_code_o), .sweep_o(sweep_o),
  .rd_idx_i(rd_idx_i), .rd_bin_o(rd_bin_o), .skew_o(skew_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/jitter_hist_acc_tb.sv
module jitter_hist_acc_tb;
  localparam int NC = 8;
  localparam int NS = 40;
  localparam int CW = 5;
  localparam int FW = 4;
  localparam int CODE_W = 3;
  localparam int SKEW_W = CODE_W + FW + 1;
  localparam int MAXC = (1 << CW) - 1;
  localparam int TOTAL = 2 * NC * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sample_i = 1'b0;
  logic rd_sweep_i = 1'b0;
  logic [CODE_W-1:0] rd_idx_i = '0;
  logic [CODE_W-1:0] delay_code_o;
  logic sweep_o, busy_o, done_o;
  logic [CW-1:0] rd_bin_o;
  logic signed [SKEW_W-1:0] skew_o;

  int n_chk = 0;
  int n_fail = 0;
  int thr [2][NC];

  always #5 clk = ~clk;

  jitter_hist_acc #(.NCODES(NC), .NSAMP(NS), .CNT_W(CW), .FRAC_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
    .delay_code_o(delay_code_o), .sweep_o(sweep_o), .rd_sweep_i(rd_sweep_i),
    .rd_idx_i(rd_idx_i), .rd_bin_o(rd_bin_o), .skew_o(skew_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int s, input int c);
    return (thr[s][c] > MAXC) ? MAXC : thr[s][c];
  endfunction

  function automatic int exp_bin(input int s, input int k);
    int d;
    if (k >= NC - 1) return 0;
    d = exp_cnt(s, k + 1) - exp_cnt(s, k);
    return (d > 0) ? d : 0;
  endfunction

  function automatic longint exp_skew();
    longint w0, t0, w1, t1, num, mag, q;
    w0 = 0; t0 = 0; w1 = 0; t1 = 0;
    for (int k = 0; k < NC - 1; k++) begin
      w0 += k * exp_bin(0, k); t0 += exp_bin(0, k);
      w1 += k * exp_bin(1, k); t1 += exp_bin(1, k);
    end
    if (t0 == 0 || t1 == 0) return 0;
    num = w1 * t0 - w0 * t1;
    mag = (num < 0) ? -num : num;
    q = (mag << FW) / (t0 * t1);
    return (num < 0) ? -q : q;
  endfunction

  task automatic run_case(input string name, input bit restart_mid);
    int mism, dones, extra;
    bit got;
    mism = 0; dones = 0; extra = 0; got = 1'b0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int t = 0; t < TOTAL; t++) begin
      int idx, s, c;
      idx = t % NS;
      s = t / (NC * NS);
      c = (t / NS) % NC;
      if (int'(delay_code_o) != c || int'(sweep_o) != s) mism++;
      sample_i = (((idx * 7) % NS) < thr[s][c]);
      start_i = restart_mid && (t == 100 || t == TOTAL - 1);
      if (done_o) dones++;
      @(negedge clk);
    end
    sample_i = 1'b0;
    start_i = 1'b0;
    chk(mism == 0, "R2", {name, " code/sweep order mismatches"}, mism, 0);
    for (int i = 0; i < 200 && !got; i++) begin
      if (done_o) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, "R7", {name, " done seen"}, got, 1);
    chk(!busy_o, "R7", {name, " busy low at done"}, busy_o, 0);
    chk(skew_o == exp_skew(), "R5", {name, " skew"}, skew_o, exp_skew());
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk(dones + extra == 0, restart_mid ? "R8" : "R7", {name, " single done pulse"},
        dones + extra, 0);
    chk(skew_o == exp_skew(), "R7", {name, " skew held"}, skew_o, exp_skew());
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < NC; k++) begin
        rd_sweep_i = s[0];
        rd_idx_i = k[CODE_W-1:0];
        #1;
        chk(int'(rd_bin_o) == exp_bin(s, k), (k == NC - 1) ? "R4" : "R3",
            {name, " bin"}, rd_bin_o, exp_bin(s, k));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    chk(delay_code_o == '0, "R1", "code in reset", delay_code_o, 0);
    chk(sweep_o == 1'b0, "R1", "sweep in reset", sweep_o, 0);
    chk(skew_o == '0, "R1", "skew in reset", skew_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "idle after reset", busy_o, 0);

    // R3: ramp with saturation at the top code, identical sweeps
    for (int c = 0; c < NC; c++) begin thr[0][c] = c * 5; thr[1][c] = c * 5; end
    run_case("ramp", 1'b0);
    // R5: step edge moves later in sweep 1, positive skew
    for (int c = 0; c < NC; c++) begin thr[0][c] = (c > 2) ? NS : 0; thr[1][c] = (c > 5) ? NS : 0; end
    run_case("step_pos", 1'b0);
    chk(skew_o == 48, "R5", "step_pos literal", skew_o, 48);
    for (int c = 0; c < NC; c++) begin thr[0][c] = (c > 5) ? NS : 0; thr[1][c] = (c > 2) ? NS : 0; end
    run_case("step_neg", 1'b0);
    chk(skew_o == -48, "R5", "step_neg literal", skew_o, -48);
    // R6: empty histograms
    for (int c = 0; c < NC; c++) begin thr[0][c] = 0; thr[1][c] = 0; end
    run_case("all_zero", 1'b0);
    for (int c = 0; c < NC; c++) begin thr[0][c] = 17; thr[1][c] = (c > 3) ? NS : 0; end
    run_case("flat_vs_step", 1'b0);
    chk(skew_o == 0, "R6", "flat sweep gives zero", skew_o, 0);
    // R4: non-monotone counts clamp negative differences
    for (int c = 0; c < NC; c++) begin thr[0][c] = (c % 2) ? 25 : 4; thr[1][c] = (c % 3) * 12; end
    run_case("zigzag", 1'b0);
    // R8: start pulses while busy
    for (int c = 0; c < NC; c++) begin thr[0][c] = (c > 2) ? NS : 0; thr[1][c] = (c > 5) ? NS : 0; end
    run_case("restart_ignored", 1'b1);
    chk(skew_o == 48, "R8", "restart skew unchanged", skew_o, 48);
    // R5: random thresholds
    for (int r = 0; r < 30; r++) begin
      for (int c = 0; c < NC; c++) begin
        thr[0][c] = $urandom_range(NS, 0);
        thr[1][c] = $urandom_range(NS, 0);
      end
      run_case("random", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule